// File: doc/BRIEF.md
# Byte-Stream Video Timing Decoder

This block sits behind a standard-definition digital video source that delivers an 8-bit 4:2:2 component stream at one byte per pixel-clock cycle (27 MHz in the target system). Line and field timing is carried inside the stream rather than on separate wires. Each timing reference is a four-byte group: three fixed prefix bytes (all-ones, zero, zero) followed by a status byte. The decoder finds these groups and decodes the status byte into a field identifier, a vertical-blanking flag and a horizontal-blanking flag. It then splits the bytes of the active picture into a tagged sample stream, so downstream logic receives each luma or chroma sample with its kind already attached.

Alongside the samples it raises single-cycle pulses for the start of each picture line, the start of each new field, and any change of field identity. It reports two kinds of stream fault. One is a status byte whose protection nibble disagrees with its flag bits. The other is a blanking byte that departs from the expected fill pattern. Bytes enter over a valid/ready port. Samples leave over a valid/ready port with one output register. The input is held off only while that register is full and the consumer is not ready. The input side never drops a byte, and the output register holds its sample unchanged until it is taken. Status flags and pulses are plain registered outputs with no handshake.

Top module: `bt656_timing_dec`

## Requirements
- R1: While `rst_n` is low and after its release, `smp_valid` and every pulse output are 0, `field_id` is 0, and `vblank` and `hblank` are 1.
- R2: A byte accepted after the three prefix bytes FFh, 00h, 00h is a status byte. Its bit 6 is the field bit F, bit 5 is V and bit 4 is H. When the status byte is valid, `field_id`, `vblank` and `hblank` take F, V and H one cycle after it is accepted. F1h decodes as F=1, V=1, H=1 and 80h decodes as F=0, V=0, H=0.
- R3: A status byte is valid only if bit 7 is 1 and bits 3..0 equal {V^H, F^H, F^V, F^V^H}. An invalid status byte pulses `prot_err` for one cycle, leaves `field_id`, `vblank` and `hblank` unchanged, and produces no line or field pulse.
- R4: A valid status byte with H=0 pulses `line_start` for one cycle.
- R5: `field_start` pulses, together with `line_start`, on the first valid status byte with H=0 and V=0 that follows a valid status byte with V=1.
- R6: `field_change` pulses when a valid status byte carries an F different from the current `field_id`.
- R7: While `hblank` and `vblank` are both 0, each accepted byte that is not a prefix or status byte appears on `smp_data` one cycle later with `smp_valid` set. The kind is set by a phase counter that restarts at every status byte and runs Cb, Y, Cr, Y: `smp_luma` is 1 for Y, and `smp_cr` is 1 only for Cr.
- R8: While `hblank` or `vblank` is 1, no byte is presented as a sample.
- R9: In blanking, a non-prefix byte at an even phase must be 80h and one at an odd phase must be 10h. Any other value pulses `fill_err` one cycle later.
- R10: An FFh byte is always treated as the start of a prefix and is never output as a sample. A 00h directly after FFh, or after FFh 00h, counts as prefix. A byte that breaks the prefix is handled as ordinary data.
- R11: `s_ready` equals `!smp_valid || smp_ready`. While `smp_valid` is 1 and `smp_ready` is 0, the sample outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input byte valid |
| s_ready | output | 1 | Input byte accepted when high with s_valid |
| s_data | input | DW (8) | Input stream byte |
| smp_valid | output | 1 | Sample available |
| smp_ready | input | 1 | Consumer takes the sample |
| smp_data | output | DW (8) | Sample value |
| smp_luma | output | 1 | Sample is luma |
| smp_cr | output | 1 | Sample is red-difference chroma |
| field_id | output | 1 | Current field bit |
| vblank | output | 1 | Vertical blanking flag |
| hblank | output | 1 | Horizontal blanking flag |
| line_start | output | 1 | Pulse: start of a picture line |
| field_start | output | 1 | Pulse: first picture line of a field |
| field_change | output | 1 | Pulse: field bit changed |
| prot_err | output | 1 | Pulse: status byte failed protection |
| fill_err | output | 1 | Pulse: wrong blanking fill byte |

## Verification
The bench targets an FFh inside the picture area: a design that emitted it, or failed to restart the prefix match, would leak a bogus sample or mislabel the samples that follow. Corrupted status bytes, including one with bit 7 clear, check that a design which trusted the flags would not flip blanking state or fire a line pulse. Field-start arming is exercised across blanking lines. A decoder that pulsed on every picture line, or never re-armed, would miss or repeat the pulse. Random consumer stalls show whether a design drops or overwrites a held sample, or accepts input while its output is full.

// File: rtl/bt656_pkg.sv
package bt656_pkg;

  typedef enum logic [1:0] {
    PH_CB = 2'd0,
    PH_Y0 = 2'd1,
    PH_CR = 2'd2,
    PH_Y1 = 2'd3
  } phase_e;

  typedef struct packed {
    logic f;
    logic v;
    logic h;
  } tstat_t;

  function automatic logic [3:0] prot_nibble(input logic f, input logic v, input logic h);
    return {v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

endpackage

// File: rtl/bt656_trs_hunt.sv
module bt656_trs_hunt #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  logic [DW-1:0] data,
  output logic          pre_byte,
  output logic          xy_byte
);
  localparam logic [DW-1:0] ALL1 = '1;
  localparam logic [DW-1:0] ZERO = '0;

  logic [1:0] pc, pc_n;

  always_comb begin
    xy_byte  = (pc == 2'd3);
    pre_byte = 1'b0;
    pc_n     = 2'd0;
    if (xy_byte) begin
      pre_byte = 1'b1;
      pc_n     = (data == ALL1) ? 2'd1 : 2'd0;
    end else if (data == ALL1) begin
      pre_byte = 1'b1;
      pc_n     = 2'd1;
    end else if ((pc == 2'd1 || pc == 2'd2) && data == ZERO) begin
      pre_byte = 1'b1;
      pc_n     = pc + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pc <= 2'd0;
    else if (acc) pc <= pc_n;
  end

  // R10: after an accepted FFh the matcher always sits at prefix position 1
  p_ff_restarts_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && data == ALL1 && pc != 2'd3) |=> (pc == 2'd1));

endmodule

// File: rtl/bt656_xy_check.sv
module bt656_xy_check
  import bt656_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] data,
  output tstat_t        stat,
  output logic          good
);
  logic [7:0] code;

  assign code   = data[DW-1 -: 8];
  assign stat.f = code[6];
  assign stat.v = code[5];
  assign stat.h = code[4];
  assign good   = code[7] && (code[3:0] == prot_nibble(code[6], code[5], code[4]));

endmodule

// File: rtl/bt656_frame_state.sv
module bt656_frame_state
  import bt656_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   xy_stb,
  input  logic   good,
  input  tstat_t stat,
  output logic   fld,
  output logic   vblank,
  output logic   hblank,
  output logic   sol,
  output logic   sof,
  output logic   fchg,
  output logic   perr
);
  logic arm;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fld    <= 1'b0;
      vblank <= 1'b1;
      hblank <= 1'b1;
      arm    <= 1'b0;
      sol    <= 1'b0;
      sof    <= 1'b0;
      fchg   <= 1'b0;
      perr   <= 1'b0;
    end else begin
      sol  <= 1'b0;
      sof  <= 1'b0;
      fchg <= 1'b0;
      perr <= 1'b0;
      if (xy_stb) begin
        if (!good) begin
          perr <= 1'b1;
        end else begin
          fld    <= stat.f;
          vblank <= stat.v;
          hblank <= stat.h;
          fchg   <= (stat.f != fld);
          sol    <= !stat.h;
          if (stat.v) begin
            arm <= 1'b1;
          end else if (!stat.h && arm) begin
            sof <= 1'b1;
            arm <= 1'b0;
          end
        end
      end
    end
  end

  // R5: a field start is always also a line start
  p_sof_with_sol_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sof |-> sol);
  // R4: a line start leaves the line out of horizontal blanking
  p_sol_in_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sol |-> !hblank);
  // R3: a rejected status byte leaves the timing flags untouched
  p_perr_keeps_state_r3: assert property (@(posedge clk) disable iff (!rst_n)
    perr |-> ($stable(fld) && $stable(vblank) && $stable(hblank) && !sol));

endmodule

// File: rtl/bt656_sample_sort.sv
module bt656_sample_sort
  import bt656_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  input  logic [DW-1:0] s_data,
  input  logic          pre_byte,
  input  logic          xy_byte,
  input  logic          active,
  output logic          s_ready,
  input  logic          smp_ready,
  output logic          smp_valid,
  output logic [DW-1:0] smp_data,
  output logic          smp_luma,
  output logic          smp_cr,
  output logic          fill_err
);
  localparam logic [DW-1:0] FILL_C = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] FILL_Y = {4'b0001, {(DW-4){1'b0}}};

  phase_e        ph;
  logic          acc, pass;
  logic [DW-1:0] fill_exp;

  assign s_ready  = !smp_valid || smp_ready;
  assign acc      = s_valid && s_ready;
  assign pass     = acc && !pre_byte;
  assign fill_exp = ph[0] ? FILL_Y : FILL_C;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph        <= PH_CB;
      smp_valid <= 1'b0;
      smp_data  <= '0;
      smp_luma  <= 1'b0;
      smp_cr    <= 1'b0;
      fill_err  <= 1'b0;
    end else begin
      fill_err <= pass && !active && (s_data != fill_exp);
      if (acc && xy_byte) ph <= PH_CB;
      else if (pass)      ph <= phase_e'(ph + 2'd1);
      if (s_ready) begin
        smp_valid <= pass && active;
        if (pass && active) begin
          smp_data <= s_data;
          smp_luma <= ph[0];
          smp_cr   <= (ph == PH_CR);
        end
      end
    end
  end

  // R11: a stalled sample is held unchanged
  p_hold_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !smp_ready) |=> (smp_valid && $stable(smp_data) && $stable(smp_luma) && $stable(smp_cr)));
  // R10: an all-ones byte never leaves as a sample
  p_no_ff_sample_r10: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> (smp_data != '1));
  // R9: a fill error coincides with no fresh sample
  p_fill_no_sample_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fill_err |-> !smp_valid);

endmodule

// File: rtl/bt656_timing_dec.sv
module bt656_timing_dec
  import bt656_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [DW-1:0] s_data,
  output logic          smp_valid,
  input  logic          smp_ready,
  output logic [DW-1:0] smp_data,
  output logic          smp_luma,
  output logic          smp_cr,
  output logic          field_id,
  output logic          vblank,
  output logic          hblank,
  output logic          line_start,
  output logic          field_start,
  output logic          field_change,
  output logic          prot_err,
  output logic          fill_err
);
  logic   acc, pre_byte, xy_byte, xy_stb, good, active;
  tstat_t stat;

  assign acc    = s_valid && s_ready;
  assign xy_stb = acc && xy_byte;
  assign active = !hblank && !vblank;

  bt656_trs_hunt #(.DW(DW)) u_hunt (
    .clk(clk), .rst_n(rst_n), .acc(acc), .data(s_data),
    .pre_byte(pre_byte), .xy_byte(xy_byte)
  );

  bt656_xy_check #(.DW(DW)) u_xy (
    .data(s_data), .stat(stat), .good(good)
  );

  bt656_frame_state u_state (
    .clk(clk), .rst_n(rst_n), .xy_stb(xy_stb), .good(good), .stat(stat),
    .fld(field_id), .vblank(vblank), .hblank(hblank),
    .sol(line_start), .sof(field_start), .fchg(field_change), .perr(prot_err)
  );

  bt656_sample_sort #(.DW(DW)) u_sort (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data),
    .pre_byte(pre_byte), .xy_byte(xy_byte), .active(active),
    .s_ready(s_ready), .smp_ready(smp_ready), .smp_valid(smp_valid),
    .smp_data(smp_data), .smp_luma(smp_luma), .smp_cr(smp_cr),
    .fill_err(fill_err)
  );

  // R8: a fresh sample is only produced from inside the picture area
  p_sample_in_picture_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ready && s_valid && !active) |=> !smp_valid);

endmodule

// File: tb/test_bt656_timing_dec.sv
module test_bt656_timing_dec;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n, s_valid, s_ready, smp_valid, smp_ready;
  logic [DW-1:0] s_data, smp_data;
  logic          smp_luma, smp_cr, field_id, vblank, hblank;
  logic          line_start, field_start, field_change, prot_err, fill_err;

  int checks = 0;
  int failures = 0;

  // reference model state
  int m_pc = 0, m_ph = 0;
  bit m_fld = 0, m_vb = 1, m_hb = 1, m_arm = 0;

  always #4 clk = ~clk;

  bt656_timing_dec #(.DW(DW)) i_bt656_timing_dec (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data),
    .smp_luma(smp_luma), .smp_cr(smp_cr), .field_id(field_id), .vblank(vblank),
    .hblank(hblank), .line_start(line_start), .field_start(field_start),
    .field_change(field_change), .prot_err(prot_err), .fill_err(fill_err)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] prot(input bit f, input bit v, input bit h);
    return {v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  task automatic send(input logic [7:0] b);
    bit e_sol = 0, e_sof = 0, e_fchg = 0, e_perr = 0, e_ferr = 0;
    bit e_smp = 0, e_luma = 0, e_cr = 0;
    logic [7:0] hold;
    if (m_pc == 3) begin
      if (!(b[7] && b[3:0] == prot(b[6], b[5], b[4]))) e_perr = 1;
      else begin
        e_fchg = (b[6] != m_fld);
        m_fld = b[6]; m_vb = b[5]; m_hb = b[4];
        e_sol = !b[4];
        if (b[5]) m_arm = 1;
        else if (!b[4] && m_arm) begin e_sof = 1; m_arm = 0; end
      end
      m_ph = 0;
      m_pc = (b == 8'hFF) ? 1 : 0;
    end else if (b == 8'hFF) m_pc = 1;
    else if ((m_pc == 1 || m_pc == 2) && b == 8'h00) m_pc++;
    else begin
      m_pc = 0;
      if (!m_hb && !m_vb) begin
        e_smp = 1; e_luma = (m_ph % 2 == 1); e_cr = (m_ph == 2);
      end else e_ferr = (b != ((m_ph % 2 == 1) ? 8'h10 : 8'h80));
      m_ph = (m_ph + 1) % 4;
    end
    @(negedge clk);
    s_data = b; s_valid = 1'b1;
    do begin
      smp_ready = ($urandom % 10) < 7;
      #1;
      if (!s_ready) begin
        hold = smp_data;
        @(negedge clk);
        chk("R11", "stall hold valid", smp_valid, 1);
        chk("R11", "stall hold data", smp_data, hold);
      end
    end while (!s_ready);
    @(posedge clk);
    @(negedge clk);
    s_valid = 1'b0;
    chk("R2", "field_id", field_id, m_fld);
    chk("R2", "vblank", vblank, m_vb);
    chk("R2", "hblank", hblank, m_hb);
    chk("R4", "line_start", line_start, e_sol);
    chk("R5", "field_start", field_start, e_sof);
    chk("R6", "field_change", field_change, e_fchg);
    chk("R3", "prot_err", prot_err, e_perr);
    chk("R9", "fill_err", fill_err, e_ferr);
    chk(e_smp ? "R7" : "R8", "smp_valid", smp_valid, e_smp);
    if (e_smp) begin
      chk("R7", "smp_data", smp_data, b);
      chk("R7", "smp_luma", smp_luma, e_luma);
      chk("R7", "smp_cr", smp_cr, e_cr);
    end
  endtask

  task automatic send_trs(input bit f, input bit v, input bit h, input logic [7:0] flip);
    send(8'hFF); send(8'h00); send(8'h00);
    send({1'b1, f, v, h, prot(f, v, h)} ^ flip);
  endtask

  task automatic send_fill(input int n);
    for (int i = 0; i < n; i++) send((i % 2 == 1) ? 8'h10 : 8'h80);
  endtask

  task automatic send_pix(input int n);
    for (int i = 0; i < n; i++) send(8'(($urandom % 254) + 1));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit f = 0;
    void'($urandom(32'd2024));
    rst_n = 1'b0; s_valid = 1'b0; s_data = '0; smp_ready = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: reset values
    chk("R1", "reset smp_valid", smp_valid, 0);
    chk("R1", "reset vblank", vblank, 1);
    chk("R1", "reset hblank", hblank, 1);
    chk("R1", "reset field_id", field_id, 0);
    chk("R1", "reset pulses", {line_start, field_start, field_change, prot_err, fill_err}, 0);
    rst_n = 1'b1;

    // R2: F1h decodes to F=1 V=1 H=1
    send(8'hFF); send(8'h00); send(8'h00); send(8'hF1);
    chk("R2", "F1 decode", {field_id, vblank, hblank}, 3'b111);
    send_fill(6);
    send_trs(1, 1, 0, 8'h00);
    chk("R5", "no field start in vblank", field_start, 0);
    send_fill(8);
    send_trs(1, 1, 1, 8'h00);
    send_fill(4);
    // R2, R5: 80h decodes to F=0 V=0 H=0 and opens a field
    send(8'hFF); send(8'h00); send(8'h00); send(8'h80);
    chk("R2", "80 decode", {field_id, vblank, hblank}, 3'b000);
    chk("R5", "field start", field_start, 1);
    chk("R6", "field change", field_change, 1);
    send_pix(12);
    // R10: FF inside the picture area is never a sample
    send(8'hFF);
    chk("R10", "FF not emitted", smp_valid, 0);
    send(8'h40);
    chk("R10", "byte after broken prefix", smp_valid, 1);
    send(8'h00);
    send_trs(0, 0, 1, 8'h00);
    send(8'h80); send(8'h55);
    chk("R9", "bad fill flagged", fill_err, 1);
    send_trs(0, 0, 0, 8'h00);
    chk("R5", "no second field start", field_start, 0);
    send_pix(6);
    send_trs(0, 0, 1, 8'h00);
    // R3: corrupted protection nibble and cleared bit 7
    send_trs(0, 0, 0, 8'h02);
    chk("R3", "bad code rejected", prot_err, 1);
    chk("R3", "bad code no line start", line_start, 0);
    send(8'h80);
    chk("R8", "still blanking after bad code", smp_valid, 0);
    send(8'h10);
    send(8'hFF); send(8'h00); send(8'h00); send(8'h00);
    chk("R3", "bit7 clear rejected", prot_err, 1);

    for (int ln = 0; ln < 150; ln++) begin
      bit v;
      int n;
      v = ($urandom % 4) == 0;
      if ($urandom % 8 == 0) f = ~f;
      send_trs(f, v, 1, ($urandom % 20 == 0) ? 8'h04 : 8'h00);
      n = (($urandom % 5) + 1) * 2;
      for (int i = 0; i < n; i++)
        send(($urandom % 30 == 0) ? 8'($urandom) : ((i % 2 == 1) ? 8'h10 : 8'h80));
      send_trs(f, v, 0, ($urandom % 25 == 0) ? 8'h01 : 8'h00);
      n = ($urandom % 20) + 4;
      for (int i = 0; i < n; i++) begin
        if ($urandom % 25 == 0) send(8'($urandom));
        else if (v) send((i % 2 == 1) ? 8'h10 : 8'h80);
        else send(8'(($urandom % 254) + 1));
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule